// File: doc/BRIEF.md
# Blanking-Absorbing Clock-Rate Bridge

This block lets a pixel-processing core run on a clock slower than the incoming pixel clock. Active pixels arrive in bursts, one per pixel-clock cycle while the input valid flag is high. The core processes them at its own slower pace and uses the horizontal blanking gap to catch up. Throughput holds as long as the core clock is at least the pixel clock times active width over total line width, plus a margin for drift between the two clocks.

Two dual-clock FIFOs with Gray-coded pointers sit on either side of the core. The input FIFO is filled on the pixel clock whenever the input valid flag is high. On the core clock, a word moves through the core only when the input FIFO holds data and the output FIFO has room. One strobe does three things in the same cycle: it pops the input FIFO, tells the core to process the word, and pushes the core's same-cycle result into the output FIFO.

Back on the pixel clock, the output FIFO is drained by a copy of the input valid flag delayed by a fixed number of cycles. The horizontal and vertical blanking flags pass through the same delay, so the output timing is the input timing shifted by `DLY` pixel cycles.

Top module: `blank_rate_bridge`

## Requirements
- R1: While either reset is high and on the first cycle after it, `out_valid`, `out_hblank`, `out_vblank` and `core_fire` are all 0.
- R2: `core_fire` is high only when the input FIFO holds a word. Words reach `core_px` in the order they were accepted on `in_data` with `in_valid` high.
- R3: Each `core_fire` cycle writes `core_res` of that same core cycle into the output FIFO. `out_data` therefore carries the core results, not the raw input pixels.
- R4: `out_valid` equals `in_valid` as sampled exactly `DLY` pixel-clock edges earlier.
- R5: `out_hblank` and `out_vblank` equal `in_hblank` and `in_vblank` delayed by the same `DLY` pixel-clock edges.
- R6: During each pixel cycle with `out_valid` high, `out_data` shows the next core result in order. Every accepted pixel appears exactly once.
- R7: With active width 64 out of a total line width of 80, and a core clock at least 8/9 of the pixel clock, the input FIFO is never full when `in_valid` is high.
- R8: With the default `DLY` and line timing, the output FIFO is never empty when `out_valid` is high, from the first pixel to the last pixel of every line.
- R9: With no input activity, once the FIFOs are drained `core_fire` stays 0 and `out_valid` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pix_clk | input | 1 | Pixel clock |
| pix_rst | input | 1 | Synchronous active-high reset, pixel domain |
| core_clk | input | 1 | Slower core clock |
| core_rst | input | 1 | Synchronous active-high reset, core domain |
| in_valid | input | 1 | Input pixel valid flag |
| in_data | input | DW | Input pixel |
| in_hblank | input | 1 | Input horizontal blanking flag |
| in_vblank | input | 1 | Input vertical blanking flag |
| core_px | output | DW | Pixel presented to the core |
| core_fire | output | 1 | Core strobe: pop input, process, push result |
| core_res | input | DW | Core result for `core_px`, valid in the same cycle |
| out_valid | output | 1 | Delayed valid flag; output FIFO read strobe |
| out_data | output | DW | Output pixel |
| out_hblank | output | 1 | Delayed horizontal blanking flag |
| out_vblank | output | 1 | Delayed vertical blanking flag |

## Verification
Two pairs of events can land in the same cycle, and both are exercised.

The first pair is on the input FIFO. At the start of every line it goes from empty to one word, so a write on the pixel side and a pop on the core side fall close together with the empty flag changing between them.

The second pair is on the output FIFO. With short lines and short blanking it runs near empty, so a core push and a delayed-valid pop hit the same entry in overlapping cycles.

Both are provoked with directed line patterns at several active/blanking ratios, including the tightest one the clock ratio allows. They are judged by comparing each output pixel, in order, against a sequence number transformed by the stub core. A bench shift register checks the delayed valid and blanking flags cycle by cycle.

// File: rtl/brb_pkg.sv
package brb_pkg;

    typedef struct packed {
        logic valid;
        logic hblank;
        logic vblank;
    } ctl_t;

    localparam ctl_t CTL_IDLE = '{valid: 1'b0, hblank: 1'b0, vblank: 1'b0};

    function automatic logic [31:0] gray_of(input logic [31:0] b);
        return b ^ (b >> 1);
    endfunction

endpackage

// File: rtl/brb_sync2.sv
module brb_sync2 #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stage[i] <= '0;
        end else begin
            stage[0] <= d;
            for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
        end
    end

    assign q = stage[STAGES-1];
endmodule

// File: rtl/brb_async_fifo.sv
module brb_async_fifo #(
    parameter int DW = 16,
    parameter int AW = 5
) (
    input  logic          wclk,
    input  logic          wrst,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    output logic          full,
    input  logic          rclk,
    input  logic          rrst,
    input  logic          rd_en,
    output logic [DW-1:0] rd_data,
    output logic          empty
);
    import brb_pkg::*;

    localparam int DEPTH = 1 << AW;
    localparam int PW    = AW + 1;

    logic [DW-1:0] mem [DEPTH];

    logic [PW-1:0] wbin, wgray, wbin_nx, wgray_nx, rgray_w;
    logic [PW-1:0] rbin, rgray, rbin_nx, rgray_nx, wgray_r;
    logic          do_wr, do_rd;

    assign do_wr = wr_en && !full;
    assign do_rd = rd_en && !empty;

    // write side
    always_comb begin
        wbin_nx  = wbin + PW'(do_wr);
        wgray_nx = PW'(gray_of(32'(wbin_nx)));
    end

    always_ff @(posedge wclk) begin
        if (wrst) begin
            wbin  <= '0;
            wgray <= '0;
            full  <= 1'b0;
        end else begin
            wbin  <= wbin_nx;
            wgray <= wgray_nx;
            full  <= (wgray_nx == {~rgray_w[PW-1:PW-2], rgray_w[PW-3:0]});
        end
    end

    always_ff @(posedge wclk) begin
        if (do_wr) mem[wbin[AW-1:0]] <= wr_data;
    end

    // read side
    always_comb begin
        rbin_nx  = rbin + PW'(do_rd);
        rgray_nx = PW'(gray_of(32'(rbin_nx)));
    end

    always_ff @(posedge rclk) begin
        if (rrst) begin
            rbin  <= '0;
            rgray <= '0;
            empty <= 1'b1;
        end else begin
            rbin  <= rbin_nx;
            rgray <= rgray_nx;
            empty <= (rgray_nx == wgray_r);
        end
    end

    assign rd_data = mem[rbin[AW-1:0]];

    brb_sync2 #(.W(PW), .STAGES(2)) u_r2w (
        .clk(wclk), .rst(wrst), .d(rgray), .q(rgray_w)
    );

    brb_sync2 #(.W(PW), .STAGES(2)) u_w2r (
        .clk(rclk), .rst(rrst), .d(wgray), .q(wgray_r)
    );
endmodule

// File: rtl/brb_ctl_delay.sv
module brb_ctl_delay #(
    parameter int DLY = 24
) (
    input  logic           clk,
    input  logic           rst,
    input  brb_pkg::ctl_t  d,
    output brb_pkg::ctl_t  q
);
    import brb_pkg::*;

    generate
        if (DLY == 0) begin : g_wire
            assign q = d;
        end else begin : g_pipe
            ctl_t pipe [DLY];
            always_ff @(posedge clk) begin
                if (rst) begin
                    for (int i = 0; i < DLY; i++) pipe[i] <= CTL_IDLE;
                end else begin
                    pipe[0] <= d;
                    for (int i = 1; i < DLY; i++) pipe[i] <= pipe[i-1];
                end
            end
            assign q = pipe[DLY-1];
        end
    endgenerate
endmodule

// File: rtl/blank_rate_bridge.sv
module blank_rate_bridge #(
    parameter int DW    = 16,
    parameter int DEPTH = 32,
    parameter int DLY   = 24
) (
    input  logic          pix_clk,
    input  logic          pix_rst,
    input  logic          core_clk,
    input  logic          core_rst,
    input  logic          in_valid,
    input  logic [DW-1:0] in_data,
    input  logic          in_hblank,
    input  logic          in_vblank,
    output logic [DW-1:0] core_px,
    output logic          core_fire,
    input  logic [DW-1:0] core_res,
    output logic          out_valid,
    output logic [DW-1:0] out_data,
    output logic          out_hblank,
    output logic          out_vblank
);
    import brb_pkg::*;

    localparam int AW = (DEPTH < 4) ? 2 : $clog2(DEPTH);

    logic in_full, in_empty, out_full, out_empty;
    ctl_t ctl_in, ctl_out;

    // pixel side: input FIFO fill
    brb_async_fifo #(.DW(DW), .AW(AW)) u_in_fifo (
        .wclk   (pix_clk),
        .wrst   (pix_rst),
        .wr_en  (in_valid),
        .wr_data(in_data),
        .full   (in_full),
        .rclk   (core_clk),
        .rrst   (core_rst),
        .rd_en  (core_fire),
        .rd_data(core_px),
        .empty  (in_empty)
    );

    // core side sequencing: one strobe pops, processes and pushes
    assign core_fire = !in_empty && !out_full;

    brb_async_fifo #(.DW(DW), .AW(AW)) u_out_fifo (
        .wclk   (core_clk),
        .wrst   (core_rst),
        .wr_en  (core_fire),
        .wr_data(core_res),
        .full   (out_full),
        .rclk   (pix_clk),
        .rrst   (pix_rst),
        .rd_en  (ctl_out.valid),
        .rd_data(out_data),
        .empty  (out_empty)
    );

    // pixel side: delayed replica of the input timing
    assign ctl_in = '{valid: in_valid, hblank: in_hblank, vblank: in_vblank};

    brb_ctl_delay #(.DLY(DLY)) u_delay (
        .clk(pix_clk), .rst(pix_rst), .d(ctl_in), .q(ctl_out)
    );

    assign out_valid  = ctl_out.valid;
    assign out_hblank = ctl_out.hblank;
    assign out_vblank = ctl_out.vblank;
endmodule

// File: rtl/brb_checker.sv
module brb_checker #(
    parameter int DLY = 24
) (
    input logic pix_clk,
    input logic pix_rst,
    input logic core_clk,
    input logic core_rst,
    input logic in_valid,
    input logic out_valid,
    input logic out_hblank,
    input logic out_vblank,
    input logic core_fire,
    input logic in_full,
    input logic out_empty
);
    int pend;

    always_ff @(posedge pix_clk) begin
        if (pix_rst) pend <= 0;
        else         pend <= pend + int'(in_valid) - int'(out_valid);
    end

    // R8: delayed read never meets an empty output FIFO
    a_r8_no_underflow: assert property (@(posedge pix_clk) disable iff (pix_rst)
        out_valid |-> !out_empty);

    // R7: input never written while full
    a_r7_no_overflow: assert property (@(posedge pix_clk) disable iff (pix_rst)
        in_valid |-> !in_full);

    // R4: accepted minus emitted pixels stay within the delay window
    a_r4_pending_window: assert property (@(posedge pix_clk) disable iff (pix_rst)
        (pend >= 0) && (pend <= DLY));

    // R1: outputs quiet on the cycle after reset
    a_r1_quiet_after_reset: assert property (@(posedge pix_clk) disable iff (pix_rst)
        $past(pix_rst) |-> (!out_valid && !out_hblank && !out_vblank));

    // R1: no core strobe right after core reset
    a_r1_core_quiet: assert property (@(posedge core_clk) disable iff (core_rst)
        $past(core_rst) |-> !core_fire);
endmodule

bind blank_rate_bridge brb_checker #(.DLY(DLY)) u_brb_checker (
    .pix_clk   (pix_clk),
    .pix_rst   (pix_rst),
    .core_clk  (core_clk),
    .core_rst  (core_rst),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .out_hblank(out_hblank),
    .out_vblank(out_vblank),
    .core_fire (core_fire),
    .in_full   (in_full),
    .out_empty (out_empty)
);

// File: tb/test_blank_rate_bridge.sv
`timescale 1ns/1ps
module test_blank_rate_bridge;
    localparam int DW  = 16;
    localparam int DLY = 24;
    localparam logic [DW-1:0] XMASK = 16'h5A5A;

    logic pix_clk = 0, core_clk = 0;
    logic pix_rst = 1, core_rst = 1;
    logic in_valid = 0, in_hblank = 0, in_vblank = 0;
    logic [DW-1:0] in_data = '0;
    logic [DW-1:0] core_px, core_res, out_data;
    logic core_fire, out_valid, out_hblank, out_vblank;

    always #2    pix_clk  = ~pix_clk;   // 250 MHz
    always #2.25 core_clk = ~core_clk;  // 8/9 of pixel rate

    assign core_res = core_px ^ XMASK;  // stand-in core

    blank_rate_bridge #(.DW(DW), .DEPTH(32), .DLY(DLY)) i_blank_rate_bridge (
        .pix_clk, .pix_rst, .core_clk, .core_rst,
        .in_valid, .in_data, .in_hblank, .in_vblank,
        .core_px, .core_fire, .core_res,
        .out_valid, .out_data, .out_hblank, .out_vblank
    );

    int checks = 0, failures = 0;
    int tx_cnt = 0, rx_cnt = 0, core_cnt = 0;
    bit mon_on = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // bench model of the timing delay
    logic [2:0] mdl [DLY];
    always @(posedge pix_clk) begin
        if (pix_rst) begin
            for (int i = 0; i < DLY; i++) mdl[i] <= 3'b000;
        end else begin
            mdl[0] <= {in_valid, in_hblank, in_vblank};
            for (int i = 1; i < DLY; i++) mdl[i] <= mdl[i-1];
        end
    end

    // pixel-side monitor
    always @(negedge pix_clk) begin
        if (mon_on && !pix_rst) begin
            check(out_valid == mdl[DLY-1][2], "R4", "out_valid", int'(out_valid), int'(mdl[DLY-1][2]));
            check(out_hblank == mdl[DLY-1][1], "R5", "out_hblank", int'(out_hblank), int'(mdl[DLY-1][1]));
            check(out_vblank == mdl[DLY-1][0], "R5", "out_vblank", int'(out_vblank), int'(mdl[DLY-1][0]));
            if (out_valid) begin
                // R3 result path, R6 ordering, R8 no underflow
                check(out_data == (DW'(rx_cnt) ^ XMASK), "R3/R6/R8", "out_data",
                      int'(out_data), int'(DW'(rx_cnt) ^ XMASK));
                rx_cnt++;
            end
        end
    end

    // core-side monitor
    always @(negedge core_clk) begin
        if (mon_on && !core_rst && core_fire) begin
            check(core_px == DW'(core_cnt), "R2", "core_px", int'(core_px), core_cnt);
            core_cnt++;
        end
    end

    task automatic drive_line(input int act, input int blank, input bit vb);
        for (int c = 0; c < act + blank; c++) begin
            @(negedge pix_clk);
            in_vblank = vb;
            in_hblank = (c >= act);
            in_valid  = !vb && (c < act);
            in_data   = in_valid ? DW'(tx_cnt) : 16'hDEAD;
            if (in_valid) tx_cnt++;
        end
        @(negedge pix_clk);
        in_valid = 0; in_hblank = 0; in_vblank = 0;
    endtask

    task automatic drain;
        repeat (DLY + 40) @(negedge pix_clk);
    endtask

    task automatic t_reset;
        repeat (2) @(negedge pix_clk);
        check(out_valid == 0, "R1", "out_valid in reset", int'(out_valid), 0);
        check(out_hblank == 0 && out_vblank == 0, "R1", "blank flags in reset",
              int'({out_hblank, out_vblank}), 0);
        check(core_fire == 0, "R1", "core_fire in reset", int'(core_fire), 0);
        @(negedge pix_clk);
        pix_rst = 0; core_rst = 0;
        @(negedge pix_clk);
        check(out_valid == 0 && out_hblank == 0 && out_vblank == 0, "R1",
              "outputs after reset", int'({out_valid, out_hblank, out_vblank}), 0);
        check(core_fire == 0, "R1", "core_fire after reset", int'(core_fire), 0);
        mon_on = 1;
    endtask

    task automatic t_full_lines;
        for (int l = 0; l < 6; l++) drive_line(64, 16, 0);
        drain();
        check(rx_cnt == tx_cnt, "R7", "pixels out after full-rate lines", rx_cnt, tx_cnt);
    endtask

    task automatic t_frame_with_vblank;
        for (int l = 0; l < 3; l++) drive_line(40, 16, 1);
        for (int l = 0; l < 4; l++) drive_line(48, 20, 0);
        drive_line(40, 16, 1);
        drain();
        check(rx_cnt == tx_cnt, "R6", "pixels out after frame", rx_cnt, tx_cnt);
    endtask

    task automatic t_short_lines;
        for (int l = 0; l < 12; l++) drive_line(8, 4, 0);
        for (int l = 0; l < 6; l++) drive_line(1, 3, 0);
        drain();
        check(rx_cnt == tx_cnt, "R6", "pixels out after short lines", rx_cnt, tx_cnt);
    endtask

    task automatic t_idle;
        int seen_rx, seen_core;
        seen_rx = rx_cnt; seen_core = core_cnt;
        repeat (60) begin
            @(negedge pix_clk);
            check(out_valid == 0, "R9", "out_valid while idle", int'(out_valid), 0);
            check(core_fire == 0, "R9", "core_fire while idle", int'(core_fire), 0);
        end
        check(rx_cnt == seen_rx && core_cnt == seen_core, "R9", "no words while idle",
              rx_cnt + core_cnt, seen_rx + seen_core);
    endtask

    initial begin
        repeat (150000) @(posedge pix_clk);
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", rx_cnt, tx_cnt);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        t_reset();
        t_full_lines();
        t_frame_with_vblank();
        t_short_lines();
        t_idle();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule